// File: doc/BRIEF.md
# Compressed Audio Burst Detector

This block sits behind the subframe decoder of a digital audio receiver. It examines the 16-bit audio words that the decoder delivers and reports whether the stream carries compressed data rather than linear PCM. It flags two kinds of stream. The first is a burst stream that starts each burst with a six-word preamble. The second is a DTS-CD stream that is recognised by its sync word, in either the 14-bit or the 16-bit word format.

Each flag is sticky. A detection sets it, and it stays set until a fixed number of frame boundaries pass with no new detection. After each preamble, the block stores the two words that follow: the burst information word and the burst length word. A combined output is high while either flag is set. Downstream logic can use it to mute the PCM path.

Top module: `burst_detect`

## Requirements
- R1: The valid words 0x0000, 0x0000, 0x0000, 0x0000, 0xF872, 0x4E1F, received in that order, set `npcm_o`. It reads high from the clock edge that accepts 0x4E1F.
- R2: Only cycles with `word_vld_i` high advance the matching. Idle cycles between the words of a pattern do not break it.
- R3: A word that does not fit the pattern abandons the current attempt. If that word equals the first word of the pattern, it begins a new attempt. A run of more than four 0x0000 words followed by 0xF872, 0x4E1F still counts as a preamble.
- R4: The first valid word after a detected preamble is stored on `burst_info_o`. The second valid word is stored on `burst_len_o`. At all other times both outputs hold their value, including after a preamble that was broken off.
- R5: `npcm_o` clears on the 4096th `frame_i` strobe after the last detection, counting only strobes with no detection in between. A new detection restarts the count.
- R6: With `dts16_en_i` high, the valid words 0x7FFE then 0x8001 set `dtscd_o`.
- R7: With `dts14_en_i` high, the valid words 0x1FFF, 0xE800, 0x07Fx set `dtscd_o`. The low 4 bits of the third word are not compared.
- R8: A DTS form whose enable is low does not set `dtscd_o`.
- R9: `dtscd_o` clears on the 4096th `frame_i` strobe after the last DTS detection. A new detection restarts the count.
- R10: `auto_o` is high exactly when `npcm_o` or `dtscd_o` is high.
- R11: Reset clears both flags, the timeout counters and both stored words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | 16 | Decoded audio word |
| word_vld_i | input | 1 | `word_i` is valid this cycle |
| frame_i | input | 1 | Frame-boundary strobe, one cycle per frame |
| dts14_en_i | input | 1 | Enables detection of the 14-bit DTS sync form |
| dts16_en_i | input | 1 | Enables detection of the 16-bit DTS sync form |
| npcm_o | output | 1 | Burst preamble seen recently |
| dtscd_o | output | 1 | DTS sync seen recently |
| auto_o | output | 1 | OR of the two flags |
| burst_info_o | output | 16 | Word captured after the preamble |
| burst_len_o | output | 16 | Second word captured after the preamble |

## Verification
Every result is registered once. A flag therefore reads high in the cycle after the edge that accepts the last sync word. A flag drops in the cycle after the edge that takes the timeout-th frame strobe. Each captured word appears in the cycle after the edge that accepts it. The bench drives one input cycle per task call on the falling edge and samples on the next falling edge, which is exactly one edge later. The timeout checks sample one strobe before the limit and again at the limit, which pins the boundary to a single frame.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int unsigned WORD_W = 16;

  localparam int unsigned PRE_LEN  = 6;
  localparam int unsigned PRE_LEAD = 4;
  localparam logic [PRE_LEN-1:0][WORD_W-1:0] PRE_PAT =
    {16'h4E1F, 16'hF872, 16'h0000, 16'h0000, 16'h0000, 16'h0000};
  localparam logic [PRE_LEN-1:0][WORD_W-1:0] PRE_MASK = {PRE_LEN{16'hFFFF}};

  localparam int unsigned D16_LEN  = 2;
  localparam logic [D16_LEN-1:0][WORD_W-1:0] D16_PAT  = {16'h8001, 16'h7FFE};
  localparam logic [D16_LEN-1:0][WORD_W-1:0] D16_MASK = {D16_LEN{16'hFFFF}};

  localparam int unsigned D14_LEN  = 3;
  localparam logic [D14_LEN-1:0][WORD_W-1:0] D14_PAT  =
    {16'h07F0, 16'hE800, 16'h1FFF};
  localparam logic [D14_LEN-1:0][WORD_W-1:0] D14_MASK =
    {16'hFFF0, 16'hFFFF, 16'hFFFF};
endpackage

// File: rtl/burst_seq_match.sv
module burst_seq_match #(
  parameter int unsigned W    = 16,
  parameter int unsigned N    = 2,
  parameter int unsigned LEAD = 1,
  parameter logic [N-1:0][W-1:0] PAT  = '0,
  parameter logic [N-1:0][W-1:0] MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] word_i,
  input  logic         vld_i,
  output logic         hit_o
);
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  eq;
  logic [IW-1:0] idx_q, idx_d;
  logic          cur;

  for (genvar k = 0; k < N; k++) begin : g_cmp
    assign eq[k] = ((word_i ^ PAT[k]) & MASK[k]) == '0;
  end

  always_comb begin
    cur   = eq[idx_q];
    hit_o = vld_i && cur && (idx_q == IW'(N-1));
    idx_d = idx_q;
    if (vld_i) begin
      if (cur)             idx_d = hit_o ? '0 : idx_q + 1'b1;
      // a word equal to the lead word restarts; a full lead run is kept
      else if (eq[0])      idx_d = (idx_q == IW'(LEAD)) ? IW'(LEAD) : IW'(1);
      else                 idx_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else         idx_q <= idx_d;
  end
endmodule

// File: rtl/burst_hold_timer.sv
module burst_hold_timer #(
  parameter int unsigned TIMEOUT = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic frame_i,
  output logic flag_o
);
  localparam int unsigned CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      cnt_q  <= '0;
    end else if (hit_i) begin
      flag_o <= 1'b1;
      cnt_q  <= '0;
    end else if (frame_i && flag_o) begin
      if (cnt_q == CW'(TIMEOUT-1)) begin
        flag_o <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/burst_capture.sv
module burst_capture #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hit_i,
  input  logic         vld_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] info_o,
  output logic [W-1:0] len_o
);
  typedef enum logic [1:0] {CAP_IDLE, CAP_INFO, CAP_LEN} cap_e;
  cap_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= CAP_IDLE;
      info_o <= '0;
      len_o  <= '0;
    end else if (hit_i) begin
      st_q <= CAP_INFO;
    end else if (vld_i) begin
      unique case (st_q)
        CAP_INFO: begin info_o <= word_i; st_q <= CAP_LEN;  end
        CAP_LEN:  begin len_o  <= word_i; st_q <= CAP_IDLE; end
        default:  st_q <= CAP_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/burst_detect.sv
module burst_detect
  import burst_pkg::*;
#(
  parameter int unsigned FRAME_TIMEOUT = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_vld_i,
  input  logic              frame_i,
  input  logic              dts14_en_i,
  input  logic              dts16_en_i,
  output logic              npcm_o,
  output logic              dtscd_o,
  output logic              auto_o,
  output logic [WORD_W-1:0] burst_info_o,
  output logic [WORD_W-1:0] burst_len_o
);
  logic pre_hit, d16_hit, d14_hit, dts_hit;

  burst_seq_match #(.W(WORD_W), .N(PRE_LEN), .LEAD(PRE_LEAD),
                    .PAT(PRE_PAT), .MASK(PRE_MASK)) u_pre (
    .clk_i, .rst_ni, .word_i, .vld_i(word_vld_i), .hit_o(pre_hit));

  burst_seq_match #(.W(WORD_W), .N(D16_LEN), .LEAD(1),
                    .PAT(D16_PAT), .MASK(D16_MASK)) u_d16 (
    .clk_i, .rst_ni, .word_i, .vld_i(word_vld_i), .hit_o(d16_hit));

  burst_seq_match #(.W(WORD_W), .N(D14_LEN), .LEAD(1),
                    .PAT(D14_PAT), .MASK(D14_MASK)) u_d14 (
    .clk_i, .rst_ni, .word_i, .vld_i(word_vld_i), .hit_o(d14_hit));

  assign dts_hit = (d16_hit && dts16_en_i) || (d14_hit && dts14_en_i);

  burst_hold_timer #(.TIMEOUT(FRAME_TIMEOUT)) u_npcm_tmr (
    .clk_i, .rst_ni, .hit_i(pre_hit), .frame_i, .flag_o(npcm_o));

  burst_hold_timer #(.TIMEOUT(FRAME_TIMEOUT)) u_dts_tmr (
    .clk_i, .rst_ni, .hit_i(dts_hit), .frame_i, .flag_o(dtscd_o));

  burst_capture #(.W(WORD_W)) u_cap (
    .clk_i, .rst_ni, .hit_i(pre_hit), .vld_i(word_vld_i), .word_i,
    .info_o(burst_info_o), .len_o(burst_len_o));

  assign auto_o = npcm_o | dtscd_o;
endmodule

// File: rtl/burst_detect_chk.sv
module burst_detect_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] word_i,
  input logic        word_vld_i,
  input logic        frame_i,
  input logic        dts14_en_i,
  input logic        dts16_en_i,
  input logic        npcm_o,
  input logic        dtscd_o,
  input logic        auto_o,
  input logic [15:0] burst_info_o,
  input logic [15:0] burst_len_o
);
  a_r1_npcm_on_tail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(npcm_o) |-> $past(word_vld_i) && $past(word_i) == 16'h4E1F);

  a_r4_capture_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(word_vld_i) |-> $stable(burst_info_o) && $stable(burst_len_o));

  a_r5_npcm_drop_on_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(npcm_o) |-> $past(frame_i));

  a_r8_dts_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dtscd_o) |-> $past(word_vld_i) &&
      (($past(dts16_en_i) && $past(word_i) == 16'h8001) ||
       ($past(dts14_en_i) && $past(word_i[15:4]) == 12'h07F)));

  a_r9_dts_drop_on_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dtscd_o) |-> $past(frame_i));

  a_r10_auto_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (npcm_o || dtscd_o) == auto_o);
endmodule

bind burst_detect burst_detect_chk u_chk (.*);

// File: tb/burst_detect_tb.sv
`timescale 1ns/1ps
module burst_detect_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] word_i = '0;
  logic        word_vld_i = 1'b0;
  logic        frame_i = 1'b0;
  logic        dts14_en_i = 1'b0;
  logic        dts16_en_i = 1'b0;
  logic        npcm_o, dtscd_o, auto_o;
  logic [15:0] burst_info_o, burst_len_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  burst_detect u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; word_vld_i = 1'b0; frame_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic put(input logic [15:0] w);
    word_i = w; word_vld_i = 1'b1;
    @(negedge clk_i);
    word_vld_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic frames(input int n);
    frame_i = 1'b1;
    repeat (n) @(negedge clk_i);
    frame_i = 1'b0;
  endtask

  task automatic preamble();
    for (int i = 0; i < 4; i++) put(16'h0000);
    put(16'hF872); put(16'h4E1F);
  endtask

  task automatic t_reset();
    do_reset();
    chk(!npcm_o && !dtscd_o && !auto_o, "R11 flags", {npcm_o, dtscd_o, auto_o}, 0);
    chk(burst_info_o == 0 && burst_len_o == 0, "R11 words", burst_info_o, 0);
  endtask

  task automatic t_preamble_capture();
    do_reset();
    for (int i = 0; i < 4; i++) put(16'h0000);
    put(16'hF872);
    chk(!npcm_o, "R1 not before tail", npcm_o, 0);
    put(16'h4E1F);
    chk(npcm_o, "R1 npcm set", npcm_o, 1);
    chk(auto_o, "R10 auto with npcm", auto_o, 1);
    put(16'h0015);
    chk(burst_info_o == 16'h0015, "R4 info", burst_info_o, 16'h0015);
    idle(3);
    put(16'h1800);
    chk(burst_len_o == 16'h1800, "R4 len", burst_len_o, 16'h1800);
    put(16'hABCD);
    chk(burst_info_o == 16'h0015 && burst_len_o == 16'h1800, "R4 hold", burst_info_o, 16'h0015);
  endtask

  task automatic t_gaps();
    do_reset();
    put(16'h0000); idle(2); put(16'h0000); put(16'h0000); idle(5);
    put(16'h0000); idle(1); put(16'hF872); idle(3); put(16'h4E1F);
    chk(npcm_o, "R2 idle gaps", npcm_o, 1);
  endtask

  task automatic t_long_zeros();
    do_reset();
    for (int i = 0; i < 9; i++) put(16'h0000);
    put(16'hF872); put(16'h4E1F);
    chk(npcm_o, "R3 long zero run", npcm_o, 1);
  endtask

  task automatic t_broken();
    do_reset();
    for (int i = 0; i < 4; i++) put(16'h0000);
    put(16'hF872); put(16'h1234); put(16'h4E1F);
    put(16'h5555); put(16'h6666);
    chk(!npcm_o, "R3 broken pattern", npcm_o, 0);
    chk(burst_info_o == 0 && burst_len_o == 0, "R4 no capture when broken", burst_info_o, 0);
    // restart through a zero that breaks the attempt
    put(16'h0000); put(16'h0000); put(16'hF872);
    preamble();
    chk(npcm_o, "R3 restart after break", npcm_o, 1);
  endtask

  task automatic t_timeout();
    do_reset();
    preamble();
    frames(4095);
    chk(npcm_o, "R5 held at 4095", npcm_o, 1);
    frames(1);
    chk(!npcm_o, "R5 cleared at 4096", npcm_o, 0);
    chk(!auto_o, "R10 auto low", auto_o, 1'b0);
  endtask

  task automatic t_retrigger();
    do_reset();
    preamble();
    frames(4000);
    preamble();
    frames(4000);
    chk(npcm_o, "R5 retrigger held", npcm_o, 1);
    frames(95);
    chk(npcm_o, "R5 retrigger 4095", npcm_o, 1);
    frames(1);
    chk(!npcm_o, "R5 retrigger cleared", npcm_o, 0);
  endtask

  task automatic t_dts16();
    do_reset();
    dts16_en_i = 1'b1; dts14_en_i = 1'b0;
    put(16'h7FFE); put(16'h7FFE); put(16'h8001);
    chk(dtscd_o && !npcm_o, "R6 dts16 set", dtscd_o, 1);
    chk(auto_o, "R10 auto with dts", auto_o, 1);
    do_reset();
    dts16_en_i = 1'b0; dts14_en_i = 1'b1;
    put(16'h7FFE); put(16'h8001);
    chk(!dtscd_o, "R8 dts16 disabled", dtscd_o, 0);
  endtask

  task automatic t_dts14();
    do_reset();
    dts14_en_i = 1'b1; dts16_en_i = 1'b0;
    put(16'h1FFF); put(16'hE800); put(16'h07E5);
    chk(!dtscd_o, "R7 third word mismatch", dtscd_o, 0);
    put(16'h1FFF); put(16'hE800); put(16'h07F9);
    chk(dtscd_o, "R7 dts14 set", dtscd_o, 1);
    do_reset();
    dts14_en_i = 1'b0; dts16_en_i = 1'b1;
    put(16'h1FFF); put(16'hE800); put(16'h07F0);
    chk(!dtscd_o, "R8 dts14 disabled", dtscd_o, 0);
  endtask

  task automatic t_dts_timeout();
    do_reset();
    dts16_en_i = 1'b1;
    put(16'h7FFE); put(16'h8001);
    preamble();
    frames(2000);
    put(16'h7FFE); put(16'h8001);
    frames(2096);
    chk(!npcm_o && dtscd_o && auto_o, "R10 dts alone", {npcm_o, dtscd_o, auto_o}, 3);
    frames(1999);
    chk(dtscd_o, "R9 held at 4095", dtscd_o, 1);
    frames(1);
    chk(!dtscd_o && !auto_o, "R9 cleared", dtscd_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_preamble_capture();
    t_gaps();
    t_long_zeros();
    t_broken();
    t_timeout();
    t_retrigger();
    t_dts16();
    t_dts14();
    t_dts_timeout();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule